// File: doc/BRIEF.md
# IDE Programmed-I/O Strobe Timing Engine

This block produces the read and write strobes for programmed-I/O data-port transfers on a single IDE channel. All timing is counted in PCI clock cycles. A requester presents a direction and a target drive with a valid/ready handshake. The engine then pulls the matching active-low strobe low. It waits a programmed number of clocks before it first looks at IORDY, and it holds the strobe low for as long as IORDY stays low. When IORDY is seen high, the engine releases the strobe and enforces a programmed recovery gap before another strobe may begin.

An 8-bit slave timing register holds separate drive-1 fields for the primary channel (low nibble) and the secondary channel (high nibble). A static channel-select input picks the nibble that applies. Drive-1 accesses use those fields only when the channel's separate-slave-timing enable is set. Every other access uses a fixed default of 5 sample clocks and 4 recovery clocks. Timing is captured when a request is accepted, so a register write made during a transfer takes effect on the next transfer.

Top module: `ide_pio_strobe_engine`

## Requirements
- R1: After reset the timing register reads 00h, both strobes are high (inactive) and req_ready is high.
- R2: A write with cfg_wr_en high stores cfg_wr_data into the timing register, and cfg_rd_data returns the stored value from the next cycle.
- R3: With IORDY high, the strobe is low for exactly the sample-point clock count. Sample code 00 gives 5 clocks, 01 gives 4 and 10 gives 3. The sample code is in bits 3:2 of a nibble.
- R4: The reserved sample code 11 behaves as 3 clocks.
- R5: The strobe stays high for at least the recovery count between the release of one strobe and the start of the next, and for exactly that count when a request is waiting. Recovery code 00 gives 4 clocks, 01 gives 3, 10 gives 2 and 11 gives 1. The recovery code is in bits 1:0 of a nibble.
- R6: When chan_sel is 0 the drive-1 fields come from register bits 3:0. When chan_sel is 1 they come from bits 7:4.
- R7: A drive-0 access, or a drive-1 access with slave_tim_en low, uses 5 sample clocks and 4 recovery clocks whatever the register holds.
- R8: If IORDY is low at the sample point, the strobe stays low and IORDY is sampled every clock. The strobe rises on the edge that samples IORDY high.
- R9: req_ready is low while a strobe is active and until the recovery count expires. A request offered while req_ready is low does not change the transfer in progress.
- R10: A write drives iow_n low and a read drives ior_n low. Both strobes are never low at the same time.
- R11: A transfer uses the timing captured when it was accepted. A register write during the transfer does not change that transfer's strobe length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the slave timing register |
| cfg_wr_data | input | 8 | Data to write into the slave timing register |
| cfg_rd_data | output | 8 | Current slave timing register value |
| chan_sel | input | 1 | 0 selects primary fields (bits 3:0), 1 selects secondary fields (bits 7:4) |
| slave_tim_en | input | 1 | Channel enable for separate drive-1 timing |
| req_valid | input | 1 | Transfer request is present |
| req_write | input | 1 | 1 = write (iow_n), 0 = read (ior_n) |
| req_drive | input | 1 | Target drive (0 or 1) |
| req_ready | output | 1 | Engine can accept a request this cycle |
| iordy | input | 1 | Device ready; low extends the strobe |
| ior_n | output | 1 | Active-low read strobe |
| iow_n | output | 1 | Active-low write strobe |

## Verification
A wrong count in the down-counter shows up as a strobe that is one or more clocks too long or too short. It can also show up as a gap between back-to-back strobes that differs from the recovery code. Either error is visible at the strobe pins within a few clocks of the transfer. A wrong field selection or decode shows up in the same place, because each field code on each channel and each drive yields a distinct strobe width and gap. A direction or state error shows as the wrong strobe going low, or as req_ready high while a strobe is still active. Both can be seen on the cycle right after the request is accepted.

// File: rtl/ide_pio_pkg.sv
// Package: shared types and field decoders for the IDE PIO strobe engine.
// Assumes all timing values fit in CNT_W bits (largest is 5).
package ide_pio_pkg;

    localparam int CNT_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STROBE  = 2'd1,
        ST_RECOVER = 2'd2
    } pio_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] sample;
        logic [CNT_W-1:0] recov;
    } pio_timing_t;

    // Sample-point code to clocks; the reserved code maps to the shortest value.
    function automatic logic [CNT_W-1:0] sample_clocks(input logic [1:0] code);
        case (code)
            2'b00:   sample_clocks = CNT_W'(5);
            2'b01:   sample_clocks = CNT_W'(4);
            default: sample_clocks = CNT_W'(3);
        endcase
    endfunction

    // Recovery code to clocks: inverted encoding, 4 down to 1.
    function automatic logic [CNT_W-1:0] recov_clocks(input logic [1:0] code);
        recov_clocks = CNT_W'(3'd4 - {1'b0, code});
    endfunction

endpackage

// File: rtl/ide_slave_timing_reg.sv
// Module: holds the 8-bit drive-1 timing register and picks the timing for
// the requested access. Assumes chan_sel and slave_en are quasi-static.
module ide_slave_timing_reg
    import ide_pio_pkg::*;
#(
    parameter int DEF_SAMPLE = 5,
    parameter int DEF_RECOV  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    input  logic        chan_sel,
    input  logic        slave_en,
    input  logic        drive_sel,
    output pio_timing_t timing_o
);

    logic [7:0] tim_q;
    logic [3:0] nibble;
    logic       use_slave;

    // Register storage with synchronous reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)     tim_q <= 8'h00;
        else if (wr_en) tim_q <= wr_data;
    end

    assign rd_data = tim_q;

    // Pick the channel nibble and decide between drive-1 and default timing.
    always_comb begin
        nibble    = chan_sel ? tim_q[7:4] : tim_q[3:0];
        use_slave = drive_sel & slave_en;
        if (use_slave) begin
            timing_o.sample = sample_clocks(nibble[3:2]);
            timing_o.recov  = recov_clocks(nibble[1:0]);
        end else begin
            timing_o.sample = CNT_W'(DEF_SAMPLE);
            timing_o.recov  = CNT_W'(DEF_RECOV);
        end
    end

    // R1
    reg_reset_chk: assert property (@(posedge clk) $rose(rst_n) |-> tim_q == 8'h00)
        else $error("timing register not cleared by reset");

    // R4
    sample_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        use_slave |-> (timing_o.sample >= CNT_W'(3) && timing_o.sample <= CNT_W'(5)))
        else $error("sample count outside 3..5");

endmodule

// File: rtl/ide_strobe_fsm.sv
// Module: sequences one PIO strobe: assert, count to the first IORDY sample,
// extend while IORDY is low, release, then count recovery. Assumes the sample
// count is at least 1 and the recovery count is at least 1.
module ide_strobe_fsm
    import ide_pio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  pio_timing_t timing_i,
    input  logic        iordy,
    output logic        req_ready,
    output logic        ior_n,
    output logic        iow_n
);

    localparam int RUN_W = 8;

    pio_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rec_q;
    logic [CNT_W-1:0] smp_q;
    logic             dir_q;
    logic             accept;

    assign req_ready = (state_q == ST_IDLE) ||
                       (state_q == ST_RECOVER && cnt_q == '0);
    assign accept    = req_valid && req_ready;

    // State, counter and captured timing update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            rec_q   <= '0;
            smp_q   <= '0;
            dir_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_STROBE: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (iordy) begin
                        state_q <= ST_RECOVER;
                        cnt_q   <= rec_q - 1'b1;
                    end
                end
                default: begin
                    if (accept) begin
                        state_q <= ST_STROBE;
                        cnt_q   <= timing_i.sample - 1'b1;
                        smp_q   <= timing_i.sample;
                        rec_q   <= timing_i.recov;
                        dir_q   <= req_write;
                    end else if (state_q == ST_RECOVER) begin
                        if (cnt_q == '0) state_q <= ST_IDLE;
                        else             cnt_q   <= cnt_q - 1'b1;
                    end
                end
            endcase
        end
    end

    // Strobe decode from state and captured direction.
    always_comb begin
        ior_n = !(state_q == ST_STROBE && !dir_q);
        iow_n = !(state_q == ST_STROBE &&  dir_q);
    end

    // Checker counters: cycles spent in the strobe and since its release.
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] gap_q;

    // Track strobe length and recovery length for the timing assertions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            gap_q <= '0;
        end else begin
            if (accept)                                  run_q <= '0;
            else if (state_q == ST_STROBE && run_q != '1) run_q <= run_q + 1'b1;
            if (state_q == ST_STROBE)                    gap_q <= RUN_W'(1);
            else if (gap_q != '1)                        gap_q <= gap_q + 1'b1;
        end
    end

    // R3
    sample_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STROBE && cnt_q == '0 && iordy) |-> (run_q + 1'b1) >= RUN_W'(smp_q))
        else $error("strobe released before sample point");

    // R5
    recov_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECOVER && accept) |-> gap_q >= RUN_W'(rec_q))
        else $error("recovery gap too short");

    // R8
    iordy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STROBE && cnt_q == '0 && !iordy) |=> (!ior_n || !iow_n))
        else $error("strobe released while IORDY low");

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!ior_n, !iow_n}))
        else $error("both strobes active");

    // R9 R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STROBE) |=> ($stable(dir_q) && $stable(rec_q) && $stable(smp_q)))
        else $error("captured transfer changed while busy");

endmodule

// File: rtl/ide_pio_strobe_engine.sv
// Module: top of the single-channel IDE PIO strobe timing engine. Joins the
// timing register/selector to the strobe sequencer. Assumes one channel and
// that timing is captured when a request is accepted.
module ide_pio_strobe_engine
    import ide_pio_pkg::*;
#(
    parameter int DEF_SAMPLE = 5,
    parameter int DEF_RECOV  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr_en,
    input  logic [7:0] cfg_wr_data,
    output logic [7:0] cfg_rd_data,
    input  logic       chan_sel,
    input  logic       slave_tim_en,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       req_drive,
    output logic       req_ready,
    input  logic       iordy,
    output logic       ior_n,
    output logic       iow_n
);

    pio_timing_t sel_timing;

    ide_slave_timing_reg #(
        .DEF_SAMPLE (DEF_SAMPLE),
        .DEF_RECOV  (DEF_RECOV)
    ) u_timing (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wr_data   (cfg_wr_data),
        .rd_data   (cfg_rd_data),
        .chan_sel  (chan_sel),
        .slave_en  (slave_tim_en),
        .drive_sel (req_drive),
        .timing_o  (sel_timing)
    );

    ide_strobe_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .timing_i  (sel_timing),
        .iordy     (iordy),
        .req_ready (req_ready),
        .ior_n     (ior_n),
        .iow_n     (iow_n)
    );

endmodule

// File: tb/ide_pio_strobe_engine_tb.sv
module ide_pio_strobe_engine_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [7:0] cfg_wr_data = 8'h00;
    logic [7:0] cfg_rd_data;
    logic       chan_sel = 1'b0;
    logic       slave_tim_en = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic       req_drive = 1'b0;
    logic       req_ready;
    logic       iordy = 1'b1;
    logic       ior_n;
    logic       iow_n;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ide_pio_strobe_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .chan_sel(chan_sel), .slave_tim_en(slave_tim_en),
        .req_valid(req_valid), .req_write(req_write), .req_drive(req_drive),
        .req_ready(req_ready), .iordy(iordy), .ior_n(ior_n), .iow_n(iow_n)
    );

    // Port monitor: measures strobe-low length and high gap between strobes.
    int  low_run = 0, high_run = 0, last_low = 0, last_gap = 0;
    bit  prev_act = 1'b0, seen_rel = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            low_run = 0; high_run = 0; prev_act = 1'b0; seen_rel = 1'b0;
        end else if (!ior_n || !iow_n) begin
            if (!prev_act && seen_rel) last_gap = high_run;
            low_run++;
            prev_act = 1'b1;
        end else begin
            if (prev_act) begin
                last_low = low_run; low_run = 0; high_run = 0; seen_rel = 1'b1;
            end
            high_run++;
            prev_act = 1'b0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] d);
        cfg_wr_data = d; cfg_wr_en = 1'b1;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    // Offer a request from a negedge; return on the negedge after acceptance.
    task automatic issue(input logic wr, input logic drv);
        req_write = wr; req_drive = drv; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        // R10: matching strobe low, other high
        check(wr ? "R10 iow_n" : "R10 ior_n", wr ? int'(iow_n) : int'(ior_n), 0);
        check("R10 other strobe", wr ? int'(ior_n) : int'(iow_n), 1);
    endtask

    // Two back-to-back transfers; checks strobe length and recovery gap.
    task automatic pair_check(input logic ch, input logic en, input logic drv,
                              input logic wr, input int exp_n, input int exp_r,
                              input string tag);
        chan_sel = ch; slave_tim_en = en;
        @(negedge clk);
        issue(wr, drv);
        issue(wr, drv);
        repeat (12) @(negedge clk);
        check({tag, " strobe length"}, last_low, exp_n);
        check({tag, " recovery gap"}, last_gap, exp_r);
    endtask

    function automatic int exp_sample(input int code);
        return (code == 0) ? 5 : (code == 1) ? 4 : 3;
    endfunction

    task automatic test_reset();
        check("R1 register", int'(cfg_rd_data), 0);
        check("R1 ior_n", int'(ior_n), 1);
        check("R1 iow_n", int'(iow_n), 1);
        check("R1 req_ready", int'(req_ready), 1);
    endtask

    task automatic test_regrw();
        cfg_write(8'hA5);
        check("R2 readback A5", int'(cfg_rd_data), 8'hA5);
        cfg_write(8'h3C);
        check("R2 readback 3C", int'(cfg_rd_data), 8'h3C);
    endtask

    // R3 R4 R5 R6: every sample/recovery code on the chosen channel nibble.
    task automatic test_sweep(input logic ch);
        for (int s = 0; s < 4; s++) begin
            for (int r = 0; r < 4; r++) begin
                logic [3:0] nib;
                nib = {2'(s), 2'(r)};
                cfg_write(ch ? {nib, ~nib} : {~nib, nib});
                pair_check(ch, 1'b1, 1'b1, (s % 2) == 1, exp_sample(s), 4 - r,
                           (s == 3) ? "R4 R5 R6" : "R3 R5 R6");
            end
        end
    endtask

    // R7: defaults for drive 0 and for disabled slave timing.
    task automatic test_defaults();
        cfg_write(8'hFF);
        pair_check(1'b0, 1'b1, 1'b0, 1'b0, 5, 4, "R7 drive0");
        pair_check(1'b0, 1'b0, 1'b1, 1'b1, 5, 4, "R7 en off");
        pair_check(1'b1, 1'b0, 1'b1, 1'b0, 5, 4, "R7 en off sec");
    endtask

    // R8 R9: IORDY low holds the strobe; ready stays low.
    task automatic test_iordy();
        cfg_write(8'h0A);
        chan_sel = 1'b0; slave_tim_en = 1'b1; iordy = 1'b0;
        @(negedge clk);
        issue(1'b0, 1'b1);
        repeat (7) @(negedge clk);
        check("R8 strobe held", int'(ior_n), 0);
        check("R9 ready low while waiting", int'(req_ready), 0);
        iordy = 1'b1;
        repeat (12) @(negedge clk);
        check("R8 extended length", last_low, 8);
    endtask

    // R9: a request offered during a write strobe does not alter it.
    task automatic test_busy();
        cfg_write(8'h05);
        chan_sel = 1'b0; slave_tim_en = 1'b1;
        @(negedge clk);
        issue(1'b1, 1'b1);
        req_write = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        check("R9 ready low in strobe", int'(req_ready), 0);
        check("R9 write strobe kept", int'(iow_n), 0);
        check("R9 read strobe idle", int'(ior_n), 1);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (12) @(negedge clk);
        check("R9 queued gap", last_gap, 3);
        check("R9 queued length", last_low, 4);
    endtask

    // R11: register write mid-transfer leaves it unchanged.
    task automatic test_capture();
        cfg_write(8'h08);
        chan_sel = 1'b0; slave_tim_en = 1'b1;
        @(negedge clk);
        issue(1'b0, 1'b1);
        cfg_write(8'h00);
        repeat (12) @(negedge clk);
        check("R11 captured length", last_low, 3);
        issue(1'b0, 1'b1);
        repeat (12) @(negedge clk);
        check("R11 new length", last_low, 5);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_regrw();
        test_sweep(1'b0);
        test_sweep(1'b1);
        test_defaults();
        test_iordy();
        test_busy();
        test_capture();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule